// File: doc/BRIEF.md
# I2C Serial Clock Phase Generator

This block derives the serial clock for a standard-mode or fast-mode I2C master from the functional clock. It works in two stages. A programmable prescaler first turns the functional clock into an internal tick. A phase counter then counts those ticks to form a low phase and a high phase. Each phase length is a programmed count plus a fixed offset: 7 ticks for the low phase and 5 ticks for the high phase. The offsets assume an internal tick near 12 MHz.

The protocol engine asks for clocking with a request input. While the request is held, the block produces full low-then-high periods back to back. Two single-cycle strobes tell the engine when to act on SDA. The first marks the middle of each low phase, where SDA may change. The second marks the last cycle of each high phase, where SDA is sampled.

The three timing settings are copied into holding registers on every cycle while the controller enable is low. They are frozen while it is high, so a setting changed during operation cannot disturb the running clock.

Top module: `i2c_scl_gen`

## Requirements
- R1: While the controller enable is low, or while it is high with no clock request, `scl_o` is 1 and both strobes are 0. This also holds during reset.
- R2: Each low phase lasts (low setting + 7) × (prescale + 1) functional clock cycles.
- R3: Each high phase lasts (high setting + 5) × (prescale + 1) functional clock cycles.
- R4: The prescale value p divides the functional clock by p+1, for every p from 0 to 255. A new request is handled as follows: if enable and request are both 1 in some cycle while the block is idle, `scl_o` is 0 in the next cycle.
- R5: `sda_chg` pulses exactly once per complete low phase, for one cycle. With N = low setting + 7, the pulse comes on tick number ceil(N/2) of that phase. This is cycle offset ceil(N/2)×(p+1)−1, counted from the first low cycle as offset 0.
- R6: `sda_smp` pulses for one cycle in the last cycle of every high phase, and only while `scl_o` is 1.
- R7: The prescale, low and high inputs are captured only while the enable is low. Changing them while the enable is high has no effect on any phase length.
- R8: The clock request is sampled only in the last cycle of a high phase. If it is 0 there, `scl_o` stays 1 afterwards and no further low phase starts.
- R9: Dropping the enable forces `scl_o` to 1 in the next cycle, whatever the phase, and clears the prescaler. The first low phase after re-enabling therefore has its full R2 length.
- R10: The largest settings (low and high both 255) give phases of 262×(p+1) and 260×(p+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| ctl_en | input | 1 | Controller enable; while it is low, the settings are captured and SCL is released |
| clk_req | input | 1 | Clock request from the protocol engine |
| psc_cfg | input | 8 | Prescale setting; the block divides by this value plus 1 |
| low_cfg | input | 8 | Low-phase setting; 7 ticks are added to it |
| high_cfg | input | 8 | High-phase setting; 5 ticks are added to it |
| scl_o | output | 1 | SCL level: 0 drives the line low, 1 releases it |
| sda_chg | output | 1 | One-cycle strobe at mid low phase, where SDA may change |
| sda_smp | output | 1 | One-cycle strobe in the last cycle of the high phase, where SDA is sampled |

## Verification
The delicate coincidence is the end of a high phase landing in the same cycle as the engine's decision to stop. The sample strobe fires in that cycle, and the request is also sampled there to choose between a new low phase and idle. The bench watches for the sample strobe of the last wanted period and clears the request inside that same cycle. It then expects the strobe to have been counted, SCL to stay released, and no extra low phase to appear. A second coincidence drops the enable partway through a low phase: it must cut the phase short and clear the prescaler together, so the next period is full length.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/i2c_scl_cfg.sv
// Holding registers: follow the inputs while disabled, frozen while enabled.
module i2c_scl_cfg #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_en,
  input  logic [PSC_W-1:0] psc_in,
  input  logic [CNT_W-1:0] low_in,
  input  logic [CNT_W-1:0] high_in,
  output logic [PSC_W-1:0] psc_q,
  output logic [CNT_W-1:0] low_q,
  output logic [CNT_W-1:0] high_q
);
  logic cap_en;
  assign cap_en = ~ctl_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      low_q  <= '0;
      high_q <= '0;
    end else if (cap_en) begin
      psc_q  <= psc_in;
      low_q  <= low_in;
      high_q <= high_in;
    end
  end
endmodule

// File: rtl/i2c_scl_presc.sv
// Prescaler: one tick every (psc+1) cycles while counting, cleared otherwise.
module i2c_scl_presc #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] pcnt_q, pcnt_d;

  assign tick = cnt_en && (pcnt_q == psc);

  always_comb begin
    if (!cnt_en || tick) pcnt_d = '0;
    else                 pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/i2c_scl_phase.sv
// Phase sequencer: idle / low / high with a tick down-counter and SDA strobes.
module i2c_scl_phase
  import i2c_scl_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int LOW_OFS  = 7,
  parameter int HIGH_OFS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_en,
  input  logic             clk_req,
  input  logic             tick,
  input  logic [CNT_W-1:0] low_set,
  input  logic [CNT_W-1:0] high_set,
  output logic             active,
  output logic             scl_o,
  output logic             sda_chg,
  output logic             sda_smp
);
  localparam int MAX_OFS = (LOW_OFS > HIGH_OFS) ? LOW_OFS : HIGH_OFS;
  localparam int PH_W    = $clog2((1 << CNT_W) + MAX_OFS);

  scl_phase_e      ph_q, ph_d;
  logic [PH_W-1:0] cnt_q, cnt_d;
  logic [PH_W-1:0] n_low, n_high, mid_low;
  logic            last_tick;

  assign n_low     = PH_W'(low_set) + PH_W'(LOW_OFS);
  assign n_high    = PH_W'(high_set) + PH_W'(HIGH_OFS);
  assign mid_low   = n_low >> 1;
  assign last_tick = tick && (cnt_q == '0);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (!ctl_en) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (clk_req) begin
          ph_d  = PH_LOW;
          cnt_d = n_low - 1'b1;
        end
        PH_LOW: if (last_tick) begin
          ph_d  = PH_HIGH;
          cnt_d = n_high - 1'b1;
        end else if (tick) begin
          cnt_d = cnt_q - 1'b1;
        end
        PH_HIGH: if (last_tick) begin
          if (clk_req) begin
            ph_d  = PH_LOW;
            cnt_d = n_low - 1'b1;
          end else begin
            ph_d  = PH_IDLE;
            cnt_d = '0;
          end
        end else if (tick) begin
          cnt_d = cnt_q - 1'b1;
        end
        default: begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign active  = (ph_q != PH_IDLE);
  assign scl_o   = (ph_q != PH_LOW);
  assign sda_chg = tick && (ph_q == PH_LOW) && (cnt_q == mid_low);
  assign sda_smp = last_tick && (ph_q == PH_HIGH);
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int PSC_W    = 8,
  parameter int CNT_W    = 8,
  parameter int LOW_OFS  = 7,
  parameter int HIGH_OFS = 5,
  parameter int RST_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_en,
  input  logic             clk_req,
  input  logic [PSC_W-1:0] psc_cfg,
  input  logic [CNT_W-1:0] low_cfg,
  input  logic [CNT_W-1:0] high_cfg,
  output logic             scl_o,
  output logic             sda_chg,
  output logic             sda_smp
);
  logic [RST_SYNC-1:0] rs_q;
  logic                rst_int_n;
  logic [PSC_W-1:0]    psc_h;
  logic [CNT_W-1:0]    low_h, high_h;
  logic                active, tick, presc_en;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[RST_SYNC-2:0], 1'b1};
  end
  assign rst_int_n = rs_q[RST_SYNC-1];

  i2c_scl_cfg #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .ctl_en(ctl_en),
    .psc_in(psc_cfg), .low_in(low_cfg), .high_in(high_cfg),
    .psc_q(psc_h), .low_q(low_h), .high_q(high_h)
  );

  assign presc_en = ctl_en && active;

  i2c_scl_presc #(.PSC_W(PSC_W)) u_presc (
    .clk(clk), .rst_n(rst_int_n), .cnt_en(presc_en),
    .psc(psc_h), .tick(tick)
  );

  i2c_scl_phase #(.CNT_W(CNT_W), .LOW_OFS(LOW_OFS), .HIGH_OFS(HIGH_OFS)) u_phase (
    .clk(clk), .rst_n(rst_int_n), .ctl_en(ctl_en), .clk_req(clk_req),
    .tick(tick), .low_set(low_h), .high_set(high_h),
    .active(active), .scl_o(scl_o), .sda_chg(sda_chg), .sda_smp(sda_smp)
  );
endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_en,
  input logic             clk_req,
  input logic             scl_o,
  input logic             sda_chg,
  input logic             sda_smp,
  input logic [PSC_W-1:0] psc_h,
  input logic [CNT_W-1:0] low_h,
  input logic [CNT_W-1:0] high_h
);
  // R1: no strobes while disabled
  a_r1_strobes_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> (!sda_chg && !sda_smp));

  // R9: disabling releases SCL on the next cycle
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> scl_o);

  // R5: change strobe only inside a low phase
  a_r5_chg_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    sda_chg |-> !scl_o);

  // R6: sample strobe only inside a high phase
  a_r6_smp_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    sda_smp |-> scl_o);

  // R7: holding registers frozen while enabled
  a_r7_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && $past(ctl_en)) |-> ($stable(psc_h) && $stable(low_h) && $stable(high_h)));

  // R8: with no request, a released SCL never starts a new low phase
  a_r8_no_new_low: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && !clk_req) |=> scl_o);

  // R5/R6: the two strobes never coincide
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(sda_chg && sda_smp));
endmodule

bind i2c_scl_gen i2c_scl_gen_chk #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .ctl_en(ctl_en), .clk_req(clk_req),
  .scl_o(scl_o), .sda_chg(sda_chg), .sda_smp(sda_smp),
  .psc_h(psc_h), .low_h(low_h), .high_h(high_h)
);

// File: tb/tb_i2c_scl_gen.sv
`timescale 1ns/1ps
module tb_i2c_scl_gen;
  logic       clk;
  logic       rst_n;
  logic       ctl_en;
  logic       clk_req;
  logic [7:0] psc_cfg, low_cfg, high_cfg;
  logic       scl_o, sda_chg, sda_smp;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  typedef struct {
    int len;
    int nchg;
    int off;
  } low_item_t;

  low_item_t lq[$];
  int        hq[$];

  i2c_scl_gen dut (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .clk_req(clk_req),
    .psc_cfg(psc_cfg), .low_cfg(low_cfg), .high_cfg(high_cfg),
    .scl_o(scl_o), .sda_chg(sda_chg), .sda_smp(sda_smp)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- monitor: pops expected items as phases complete
  int  cyc = 0;
  int  lstart = 0, hstart = 0, chg_n = 0, chg_at = 0;
  logic scl_prev = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (scl_prev && !scl_o) begin
      lstart = cyc;
      chg_n  = 0;
    end
    if (!scl_o && sda_chg) begin
      chg_n++;
      chg_at = cyc - lstart;
    end
    if (!scl_prev && scl_o) begin
      if (lq.size() == 0) begin
        chk(0, "R2 unexpected low phase", cyc - lstart, 0);
      end else begin
        low_item_t it;
        it = lq.pop_front();
        chk(cyc - lstart == it.len, "R2 low length", cyc - lstart, it.len);
        chk(chg_n == it.nchg, "R5 change strobe count", chg_n, it.nchg);
        if (it.nchg == 1)
          chk(chg_at == it.off, "R5 change strobe offset", chg_at, it.off);
      end
      hstart = cyc;
    end
    if (sda_smp) begin
      if (hq.size() == 0) begin
        chk(0, "R6 unexpected sample strobe", cyc - hstart, 0);
      end else begin
        int e;
        e = hq.pop_front();
        chk(cyc - hstart == e, "R3/R6 high length to sample strobe", cyc - hstart, e);
      end
    end
    scl_prev = scl_o;
  end

  // ---------------- driver
  task automatic push_period(input int p, input int l, input int h);
    low_item_t it;
    int n;
    n = l + 7;
    it.len  = n * (p + 1);
    it.nchg = 1;
    it.off  = ((n + 1) / 2) * (p + 1) - 1;
    lq.push_back(it);
    hq.push_back((h + 5) * (p + 1) - 1);
  endtask

  task automatic burst(input int p, input int l, input int h, input int n, input bit scramble);
    int seen;
    bit stay;
    @(negedge clk);
    ctl_en   = 1'b0;
    clk_req  = 1'b0;
    psc_cfg  = 8'(p);
    low_cfg  = 8'(l);
    high_cfg = 8'(h);
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < n; i++) push_period(p, l, h);
    ctl_en  = 1'b1;
    clk_req = 1'b1;
    @(negedge clk);
    chk(scl_o == 1'b0, "R4 first low one cycle after request", scl_o, 0);
    if (scramble) begin
      // R7: settings changed while enabled must be ignored
      psc_cfg  = 8'(p + 1);
      low_cfg  = 8'(l + 9);
      high_cfg = 8'(h + 3);
    end
    seen = 0;
    while (seen < n) begin
      @(negedge clk);
      if (sda_smp) seen++;
    end
    // R8: drop the request in the very cycle of the final sample strobe
    clk_req = 1'b0;
    stay = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!scl_o || sda_chg || sda_smp) stay = 1'b0;
    end
    chk(stay, "R8 idle after request dropped at sample strobe", stay, 1);
    ctl_en = 1'b0;
  endtask

  initial begin
    bit ok;
    rst_n    = 1'b0;
    ctl_en   = 1'b0;
    clk_req  = 1'b0;
    psc_cfg  = 8'd0;
    low_cfg  = 8'd0;
    high_cfg = 8'd0;
    repeat (3) @(negedge clk);
    chk(scl_o == 1'b1 && !sda_chg && !sda_smp, "R1 reset state", scl_o, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: enabled but no request
    ctl_en = 1'b1;
    ok = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!scl_o || sda_chg || sda_smp) ok = 1'b0;
    end
    chk(ok, "R1 enabled without request stays idle", ok, 1);
    ctl_en = 1'b0;

    burst(0, 0, 0, 3, 1'b0);     // R2 R3 R5 R6 minimum settings
    burst(3, 5, 2, 2, 1'b0);     // R4 divide by 4, even N
    burst(1, 10, 20, 2, 1'b1);   // R7 scramble while enabled
    burst(0, 255, 255, 1, 1'b0); // R10 largest settings
    burst(255, 0, 0, 1, 1'b0);   // R4 largest prescale

    // R9: drop enable part way through a low phase
    @(negedge clk);
    psc_cfg  = 8'd2;
    low_cfg  = 8'd3;
    high_cfg = 8'd1;
    @(negedge clk);
    @(negedge clk);
    begin
      low_item_t it;
      it.len  = 5;
      it.nchg = 0;
      it.off  = 0;
      lq.push_back(it);
    end
    ctl_en  = 1'b1;
    clk_req = 1'b1;
    @(negedge clk);
    chk(scl_o == 1'b0, "R9 low phase started", scl_o, 0);
    repeat (4) @(negedge clk);
    ctl_en  = 1'b0;
    clk_req = 1'b0;
    @(negedge clk);
    chk(scl_o == 1'b1 && !sda_chg && !sda_smp, "R9 released after disable", scl_o, 1);
    burst(2, 3, 1, 1, 1'b0);     // R9 full first period after re-enable

    repeat (10) @(negedge clk);
    chk(lq.size() == 0 && hq.size() == 0, "R2/R3 all expected phases seen",
        lq.size() + hq.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule